// File: doc/BRIEF.md
# Linear soft-mute ramp controller

This block sits in front of the input FIFO of a sample-rate converter. It scales every incoming audio sample by a gain that moves in a straight line between unity and silence. A 12-bit attenuation counter sets the gain, and the counter moves one step per period of the audio frame clock. Muting therefore fades the stream out and back in over thousands of frames, with no abrupt jump.

The mute request has two possible sources. By default it is the converter's own mute-out flag. That flag rises when the converter is switched on, or when a change of the rate ratio is signalled, and it holds for a fixed settling period. A disable control cuts this automatic path, and the external mute input then drives the ramp instead. The frame clock is asynchronous to the system clock. It is synchronised into the system domain and its rising edges are detected to make the step pulse. The sample path has one registered stage.

Top module: `soft_mute_ramp`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `out_data`, `out_valid`, `mute_out` and the attenuation count. A count of 0 means unity gain.
- R2: The attenuation count changes only on a frame step. A step is detected from the rising edge of `frame_clk` after a two-flop synchroniser. Each step changes the count by exactly one.
- R3: While the mute request is high, every step adds one to the count, up to 4095, and the count stays there. At a count of 4095 the output sample is exactly zero.
- R4: While the mute request is low, every step subtracts one from the count, down to 0, and the count stays there. At a count of 0 the output sample equals the input sample.
- R5: If the mute request changes mid-ramp, the count reverses from its present value on the next step. It never jumps.
- R6: For counts from 1 to 4094, `out_data` = trunc(`in_data` × (4095 − count) / 4096). Samples are two's-complement and the result rounds toward zero.
- R7: A rising edge of `conv_enable` sets `mute_out` on the next clock. `mute_out` clears on the clock that ends the 4096th frame step after the trigger.
- R8: A `rate_change` pulse while `conv_enable` is high restarts the 4096-step settling period. This holds even when the pulse falls in the same cycle as a frame step, where the restart wins. A pulse while `conv_enable` is low has no effect.
- R9: With `auto_mute_off` low, the mute request is `mute_out`, and `mute_ext` is ignored.
- R10: With `auto_mute_off` high, the mute request is `mute_ext`, and `mute_out` does not affect the ramp.
- R11: `out_valid` and `out_data` appear one clock after `in_valid` and `in_data`. `out_valid` repeats `in_valid` cycle for cycle.
- R12: While `conv_enable` is low, `mute_out` is low from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clk | input | 1 | Audio frame clock, asynchronous to `clk` |
| in_data | input | DATA_W | Signed input sample |
| in_valid | input | 1 | Input sample qualifier |
| out_data | output | DATA_W | Scaled sample toward the converter FIFO |
| out_valid | output | 1 | Output sample qualifier |
| conv_enable | input | 1 | Converter enable; a rising edge starts the settling period |
| rate_change | input | 1 | One-cycle strobe: a rate-ratio change was detected |
| auto_mute_off | input | 1 | 1 = external mute drives the ramp; 0 = automatic |
| mute_ext | input | 1 | External mute request |
| mute_out | output | 1 | Settling-period mute flag |

## Verification
Two events can land on the same system clock: a `rate_change` strobe and a frame step that would otherwise decrement the settling timer. The bench watches its reference model's synchroniser state and places the strobe exactly in a cycle where a frame step is being taken. It then counts the frame steps until `mute_out` falls and expects 4096, which is only true if the reload won. All along, a behavioural model of the synchroniser, timer, counter and gain arithmetic predicts `out_data`, `out_valid` and `mute_out` and compares them on every clock. The same comparison covers the other overlap: a count reversal landing on the step where the counter saturates.

// File: rtl/smr_pkg.sv
// Shared types and helpers for the soft-mute ramp controller.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package smr_pkg;

    // Direction the attenuation counter takes on the next frame step.
    typedef enum logic [1:0] {
        RAMP_HOLD = 2'b00,
        RAMP_UP   = 2'b01,
        RAMP_DOWN = 2'b10
    } ramp_dir_e;

    // Width needed to hold values 0..n.
    function automatic int unsigned span_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/smr_frame_sync.sv
// Frame-clock synchroniser and rising-edge detector.
// Brings the asynchronous frame clock through SYNC_STAGES flops and emits a
// one-cycle step pulse per rising edge. Assumes the frame clock stays high
// and low for at least two system clocks each.
module smr_frame_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_clk,
    output logic frame_tick
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Synchroniser chain, one flop per stage.
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the asynchronous clock.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= frame_clk;
                end
            end else begin : g_next
                // Later stages resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    // Rising edge of the synchronised frame clock.
    always_comb begin
        frame_tick = sync_q[SYNC_STAGES-1] & ~last_q;
    end

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> !frame_tick);

endmodule

// File: rtl/smr_init_timer.sv
// Settling-period timer that drives the mute-out flag.
// A rising enable, or a rate-change strobe while enabled, loads INIT_FRAMES
// and raises the flag; each frame step counts down; the flag clears when the
// count reaches zero. A trigger in the same cycle as a step wins.
module smr_init_timer #(
    parameter int INIT_FRAMES = 4096,
    localparam int TMR_W      = smr_pkg::span_bits(INIT_FRAMES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rate_change,
    input  logic frame_tick,
    output logic mute_out
);

    logic [TMR_W-1:0] tmr_q;
    logic             en_q;
    logic             trigger;

    // Trigger on enable rising edge or on a rate change while enabled.
    always_comb begin
        trigger = enable & (~en_q | rate_change);
    end

    // Previous enable level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= enable;
    end

    // Load, count down and clear the settling timer and its flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q    <= '0;
            mute_out <= 1'b0;
        end else if (!enable) begin
            tmr_q    <= '0;
            mute_out <= 1'b0;
        end else if (trigger) begin
            tmr_q    <= TMR_W'(INIT_FRAMES);
            mute_out <= 1'b1;
        end else if (frame_tick && (tmr_q != '0)) begin
            tmr_q <= tmr_q - 1'b1;
            if (tmr_q == TMR_W'(1)) mute_out <= 1'b0;
        end
    end

    // R7
    enable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(enable) && $past(rst_n)) |=> mute_out);
    // R8
    retrigger_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rate_change) |=> mute_out);
    // R12
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !mute_out);
    // R7
    hold_between_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_out && enable && !frame_tick) |=> mute_out);

endmodule

// File: rtl/smr_ramp_counter.sv
// Saturating up/down attenuation counter.
// Steps once per frame tick: up while mute is requested, down otherwise,
// holding at 0 and at the all-ones value. A change of request reverses the
// direction from the present value.
module smr_ramp_counter #(
    parameter int CNT_W = 12,
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic             mute_req,
    output logic [CNT_W-1:0] gain_cnt
);

    import smr_pkg::*;

    ramp_dir_e dir;

    // Choose this step's direction from the request and the saturation limits.
    always_comb begin
        dir = RAMP_HOLD;
        if (frame_tick) begin
            if (mute_req && (gain_cnt != CNT_MAX))   dir = RAMP_UP;
            else if (!mute_req && (gain_cnt != '0))  dir = RAMP_DOWN;
        end
    end

    // Apply the chosen step to the attenuation count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_cnt <= '0;
        end else begin
            unique case (dir)
                RAMP_UP:   gain_cnt <= gain_cnt + 1'b1;
                RAMP_DOWN: gain_cnt <= gain_cnt - 1'b1;
                default:   gain_cnt <= gain_cnt;
            endcase
        end
    end

    // R2
    no_step_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(gain_cnt));
    // R3
    top_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && mute_req && gain_cnt == CNT_MAX) |=> gain_cnt == CNT_MAX);
    // R4
    bottom_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !mute_req && gain_cnt == '0) |=> gain_cnt == '0);
    // R5
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && mute_req && gain_cnt != CNT_MAX) |=> gain_cnt == $past(gain_cnt) + 1'b1);
    // R5
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !mute_req && gain_cnt != '0) |=> gain_cnt == $past(gain_cnt) - 1'b1);

endmodule

// File: rtl/smr_gain_scaler.sv
// Registered sample scaler.
// out = trunc(in * (MAX - cnt) / 2^CNT_W) rounding toward zero; a count of
// zero passes the sample unchanged and the all-ones count gives zero.
// Assumes signed two's-complement samples.
module smr_gain_scaler #(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 12,
    localparam int PROD_W = DATA_W + CNT_W + 1,
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  gain_cnt,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);

    localparam logic signed [PROD_W-1:0] RND_BIAS = PROD_W'((1 << CNT_W) - 1);

    logic signed [DATA_W-1:0] sample_s;
    logic signed [CNT_W:0]    gain_s;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] biased;
    logic signed [PROD_W-1:0] shifted;
    logic        [DATA_W-1:0] scaled;

    // Multiply by the gain and shift down, rounding toward zero.
    always_comb begin
        sample_s = $signed(in_data);
        gain_s   = $signed({1'b0, CNT_MAX - gain_cnt});
        prod     = PROD_W'(sample_s) * PROD_W'(gain_s);
        biased   = prod[PROD_W-1] ? (prod + RND_BIAS) : prod;
        shifted  = biased >>> CNT_W;
        if (gain_cnt == '0)           scaled = in_data;
        else if (gain_cnt == CNT_MAX) scaled = '0;
        else                          scaled = shifted[DATA_W-1:0];
    end

    // Output register stage for data and qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_data  <= scaled;
            out_valid <= in_valid;
        end
    end

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R11
    invalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    full_mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_cnt == CNT_MAX) |=> out_data == '0);
    // R4
    unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_cnt == '0) |=> out_data == $past(in_data));

endmodule

// File: rtl/soft_mute_ramp.sv
// Linear soft-mute ramp controller (top).
// Joins the frame synchroniser, the settling timer, the attenuation counter
// and the sample scaler, and selects the mute request source.
// Assumes frame_clk phases each last two or more system clocks.
module soft_mute_ramp #(
    parameter int DATA_W      = 24,
    parameter int CNT_W       = 12,
    parameter int INIT_FRAMES = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_clk,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              conv_enable,
    input  logic              rate_change,
    input  logic              auto_mute_off,
    input  logic              mute_ext,
    output logic              mute_out
);

    logic             frame_tick;
    logic             mute_req;
    logic [CNT_W-1:0] gain_cnt;

    // Frame step generation.
    smr_frame_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_clk  (frame_clk),
        .frame_tick (frame_tick)
    );

    // Settling period and mute-out flag.
    smr_init_timer #(.INIT_FRAMES(INIT_FRAMES)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (conv_enable),
        .rate_change (rate_change),
        .frame_tick  (frame_tick),
        .mute_out    (mute_out)
    );

    // Mute source: automatic loop unless defeated.
    always_comb begin
        mute_req = auto_mute_off ? mute_ext : mute_out;
    end

    // Attenuation ramp.
    smr_ramp_counter #(.CNT_W(CNT_W)) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .mute_req   (mute_req),
        .gain_cnt   (gain_cnt)
    );

    // Sample scaling and output register.
    smr_gain_scaler #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .gain_cnt  (gain_cnt),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0 && !mute_out));
    // R9
    auto_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mute_off |-> (mute_req == mute_out));
    // R10
    manual_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_mute_off |-> (mute_req == mute_ext));

endmodule

// File: tb/soft_mute_ramp_bench.sv
// Bench: behavioural reference model compared on every clock.
module soft_mute_ramp_bench;

    localparam int DW   = 24;
    localparam int CMAX = 4095;
    localparam int INIT = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_clk = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_valid;
    logic          conv_enable = 1'b0;
    logic          rate_change = 1'b0;
    logic          auto_mute_off = 1'b0;
    logic          mute_ext = 1'b0;
    logic          mute_out;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    started = 0;
    string cur_req = "R1";

    // model state
    bit          m_s1, m_s2, m_p, m_en_q, m_mo;
    int          m_tmr, m_cnt;
    logic [DW-1:0] m_out_data;
    bit          m_out_valid;
    int          fc_phase = 0;

    soft_mute_ramp u_soft_mute_ramp (
        .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk),
        .in_data(in_data), .in_valid(in_valid),
        .out_data(out_data), .out_valid(out_valid),
        .conv_enable(conv_enable), .rate_change(rate_change),
        .auto_mute_off(auto_mute_off), .mute_ext(mute_ext),
        .mute_out(mute_out)
    );

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] ref_scale(input logic signed [DW-1:0] d, input int c);
        longint p;
        if (c == 0) return d;
        p = longint'(d) * longint'(CMAX - c);
        p = p / 4096;
        return DW'(p);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Reference model, advanced on each clock edge from the pre-edge inputs.
    always @(posedge clk) begin
        bit tick, trig, req;
        cycles++;
        started = 1;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_p = 0; m_en_q = 0; m_mo = 0;
            m_tmr = 0; m_cnt = 0; m_out_data = '0; m_out_valid = 0;
        end else begin
            tick = m_s2 && !m_p;
            req  = auto_mute_off ? mute_ext : m_mo;
            trig = conv_enable && (!m_en_q || rate_change);
            m_out_data  = ref_scale(in_data, m_cnt);
            m_out_valid = in_valid;
            if (tick) begin
                if (req && m_cnt < CMAX) m_cnt++;
                else if (!req && m_cnt > 0) m_cnt--;
            end
            if (!conv_enable) begin
                m_mo = 0; m_tmr = 0;
            end else if (trig) begin
                m_mo = 1; m_tmr = INIT;
            end else if (tick && m_tmr > 0) begin
                m_tmr--;
                if (m_tmr == 0) m_mo = 0;
            end
            m_en_q = conv_enable;
            m_p = m_s2; m_s2 = m_s1; m_s1 = frame_clk;
        end
    end

    // Compare on every clock, then drive data and the frame clock.
    always @(negedge clk) begin
        if (started) begin
            chk({cur_req, " out_valid"}, out_valid, m_out_valid);
            chk({cur_req, " out_data"}, out_data, m_out_data);
            chk({cur_req, " mute_out"}, mute_out, m_mo);
        end
        in_data   <= DW'($urandom);
        in_valid  <= ($urandom % 4) != 0;
        fc_phase  <= fc_phase + 1;
        frame_clk <= fc_phase[1];
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
            report();
        end
    end

    task automatic wait_frames(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    // Pulse rate_change in a cycle where a frame step is being taken.
    task automatic pulse_rc_on_tick;
        @(negedge clk);
        while (!(m_s2 && !m_p)) @(negedge clk);
        rate_change = 1'b1;
        @(negedge clk);
        rate_change = 1'b0;
    endtask

    initial begin
        int steps;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_data", out_data, 0);
        chk("R1 mute_out", mute_out, 0);
        rst_n = 1'b1;

        cur_req = "R11";
        wait_frames(20);

        // R9: external mute ignored in automatic mode
        cur_req = "R9";
        mute_ext = 1'b1;
        wait_frames(50);
        chk("R9 mute_out", mute_out, 0);
        mute_ext = 1'b0;

        // R7: enable starts settling period
        cur_req = "R7";
        conv_enable = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 mute_out set", mute_out, 1);

        cur_req = "R2";
        wait_frames(3000);

        // R8: rate change coincident with a frame step restarts the period
        cur_req = "R8";
        pulse_rc_on_tick();
        steps = 0;
        cur_req = "R3";
        while (mute_out) begin
            if (m_s2 && !m_p) steps++;
            if (m_cnt == CMAX && steps == 2000) chk("R3 full mute zero", out_data, 0);
            @(negedge clk);
        end
        chk("R8 steps after restart", steps, INIT);

        // R4/R6: release ramp back to unity
        cur_req = "R6";
        wait_frames(4200);
        cur_req = "R4";
        wait_frames(20);

        // R5: reversal mid-ramp under external control
        cur_req = "R5";
        auto_mute_off = 1'b1;
        mute_ext = 1'b1;
        wait_frames(1000);
        mute_ext = 1'b0;
        wait_frames(1100);

        // R10: mute_out does not drive the ramp when the loop is defeated
        cur_req = "R10";
        pulse_rc_on_tick();
        wait_frames(200);
        chk("R10 mute_out high", mute_out, 1);

        // R12: disable clears mute_out
        cur_req = "R12";
        conv_enable = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 mute_out", mute_out, 0);

        // R8: rate change while disabled ignored
        cur_req = "R8";
        rate_change = 1'b1;
        @(negedge clk);
        rate_change = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 ignored when disabled", mute_out, 0);
        wait_frames(10);
        report();
    end

endmodule